// File: doc/BRIEF.md
# I2C Bus Hang Recovery Sequencer

This block sits next to an I2C master and frees a bus that a slave has hung. The usual hang is a slave that missed a clock edge and now keeps SDA low. The slave is waiting for clocks that the master will never send, because the master sees a busy bus. The block watches two wait conditions that the master reports. One is waiting to win the bus and the other is waiting for a transfer to finish. Each has its own programmable limit. When either wait runs too long, or when the master asks for it, the block takes over both lines. It toggles SCL a fixed number of times at normal bus speed and then generates a STOP. Last, it samples SDA to report success or failure. The same sequence runs by itself once after every reset, so a hang left by power-up glitches or by a restart in mid-transfer is cleared before the first real transaction.

All line outputs are low-enables for open-drain pads: a 1 pulls the wire low and a 0 releases it. No output ever drives a line high. While idle, the master's own low-enables pass straight through. While recovery runs, the master's enables are ignored. If a slave stretches SCL during a pulse, the sequencer waits, and that wait has its own timeout. Two parameters select other variants. One replaces the pulse train with a strobe on a slave reset line. The other allows the train to stop early once SDA reads high at the end of a high phase. The interface carries no data stream: every pin is plain control or status.

Top module: `bus_unjam`

## Requirements
- R1: The sequencer comes out of reset already recovering. busy_o is 1 and scl_lo_o is 1 in the first cycle after reset is released, with sda_lo_o at 0.
- R2: A recovery emits exactly PULSES SCL pulses (default 10, with 9 as the bare byte-plus-acknowledge count). Each pulse has DIV cycles of SCL pulled low and DIV cycles of SCL read high. SDA is never pulled during the pulses. Without stretching, busy_o stays high for 2*DIV*PULSES + 3*DIV + 1 cycles.
- R3: After the pulses comes a STOP. First SCL and SDA are both pulled low. Then SCL is released while SDA stays low. Then SDA is released while SCL is high. Each step lasts DIV cycles.
- R4: One cycle after the STOP, SDA is sampled. A high level sets done_o and a low level sets fail_o. These two flags are exclusive and are held until the next recovery starts, which clears them.
- R5: While idle, if gain_wait_i is high for gain_limit_i consecutive clock edges, a recovery starts and lockup_o is set for that run. A shorter run of the wait does not start one. A limit of 0 disables this timer.
- R6: xfer_wait_i and xfer_limit_i behave like R5 as a second independent timer.
- R7: A one-cycle recov_req_i while idle starts a recovery with lockup_o at 0. recov_req_i is ignored while busy_o is high: it neither restarts nor lengthens the run.
- R8: While idle, scl_lo_o equals m_scl_lo_i and sda_lo_o equals m_sda_lo_i. While busy, the master's enables have no effect on the outputs.
- R9: When SCL is released but reads low (stretching), the high-phase count pauses. A stretch of S cycles lengthens the run by exactly S cycles.
- R10: If SCL reads low for STRETCH_LIM consecutive cycles in a high phase, the run ends at once. fail_o is set and both lines are released. busy_o is then high for DIV + STRETCH_LIM cycles in total.
- R11: With USE_SLAVE_RST=1, no SCL pulses are emitted. slave_rst_o is high for RST_CYC cycles, and then the R3 STOP and the R4 check follow. busy_o lasts RST_CYC + 3*DIV + 1 cycles.
- R12: With EARLY_EXIT=1, the train ends after any pulse whose high phase finishes with SDA high. A bus that is already free therefore takes 5*DIV + 1 busy cycles.
- R13: With EARLY_EXIT=0, all PULSES pulses are emitted even if the slave releases SDA after a few of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recov_req_i | input | 1 | Master request for a recovery |
| gain_wait_i | input | 1 | Master is waiting to win the bus |
| gain_limit_i | input | TW | Edge limit for the bus-gain wait, 0 disables it |
| xfer_wait_i | input | 1 | Master is waiting for a transfer to complete |
| xfer_limit_i | input | TW | Edge limit for the transfer wait, 0 disables it |
| m_scl_lo_i | input | 1 | Master's SCL low-enable |
| m_sda_lo_i | input | 1 | Master's SDA low-enable |
| scl_i | input | 1 | Sampled SCL wire level |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_lo_o | output | 1 | SCL pad low-enable |
| sda_lo_o | output | 1 | SDA pad low-enable |
| slave_rst_o | output | 1 | Slave reset strobe (USE_SLAVE_RST variant) |
| busy_o | output | 1 | Recovery in progress; the block owns the lines |
| done_o | output | 1 | Last recovery ended with SDA high |
| fail_o | output | 1 | Last recovery ended with SDA low or SCL stuck |
| lockup_o | output | 1 | Last recovery was started by a timeout |

## Verification
A recovery begins on the clock edge that samples the request or the final wait cycle, so busy_o is read at the falling edge that follows. The bench then counts the falling edges on which busy_o stays high and compares that count with the closed-form length for the run: 2*DIV*PULSES + 3*DIV + 1, plus S for a stretch, DIV + STRETCH_LIM for a stalled clock, RST_CYC + 3*DIV + 1 for the reset variant, and 5*DIV + 1 for early exit. For the timers, the wait is held for exactly limit-1 edges and busy_o is checked to still be low. The wait is then held for exactly limit edges and busy_o is checked to be high at the next falling edge. done_o, fail_o and lockup_o are read only after busy_o has fallen, and the pad enables are read mid-phase.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_LOW, ST_HIGH, ST_STP_A, ST_STP_B, ST_STP_C, ST_CHK
  } seq_st_t;
endpackage

// File: rtl/unjam_timeout.sv
module unjam_timeout #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          wait_i,
  input  logic [TW-1:0] limit_i,
  output logic          trip_o
);
  logic [TW-1:0] cnt;

  assign trip_o = wait_i && !hold_i && (limit_i != '0) && (cnt == limit_i - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (hold_i || !wait_i || trip_o) cnt <= '0;
    else                                 cnt <= cnt + TW'(1);
  end

  // R5/R6: the count only advances over edges where the wait was seen while idle
  assert_count_needs_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($past(wait_i) && !$past(hold_i)));
  assert_trip_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |=> (cnt == '0));
endmodule

// File: rtl/unjam_seq.sv
module unjam_seq
  import unjam_pkg::*;
#(
  parameter int DIV           = 250,
  parameter int PULSES        = 10,
  parameter int STRETCH_LIM   = 2000,
  parameter bit EARLY_EXIT    = 1'b0,
  parameter bit USE_SLAVE_RST = 1'b0,
  parameter int RST_CYC       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic lock_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy_o,
  output logic scl_lo_o,
  output logic sda_lo_o,
  output logic slave_rst_o,
  output logic done_o,
  output logic fail_o,
  output logic lockup_o
);
  localparam int PH_MAX = (DIV > RST_CYC) ? DIV : RST_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CW     = $clog2(PULSES + 1);
  localparam int SW     = $clog2(STRETCH_LIM + 1);
  localparam seq_st_t ST_FIRST = USE_SLAVE_RST ? ST_RST : ST_LOW;

  seq_st_t st, st_n;
  logic [PH_W-1:0] ph;
  logic [CW-1:0]   pc;
  logic [SW-1:0]   sc;
  logic ph_end, last_pulse, stall;

  assign busy_o     = (st != ST_IDLE);
  assign ph_end     = (ph == PH_W'(DIV - 1));
  assign last_pulse = (pc == CW'(PULSES - 1)) || (EARLY_EXIT && sda_i);
  assign stall      = (st == ST_HIGH) && !scl_i;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:  if (start_i) st_n = ST_FIRST;
      ST_RST:   if (ph == PH_W'(RST_CYC - 1)) st_n = ST_STP_A;
      ST_LOW:   if (ph_end) st_n = ST_HIGH;
      ST_HIGH: begin
        if (scl_i) begin
          if (ph_end) st_n = last_pulse ? ST_STP_A : ST_LOW;
        end else if (sc == SW'(STRETCH_LIM - 1)) begin
          st_n = ST_IDLE;
        end
      end
      ST_STP_A: if (ph_end) st_n = ST_STP_B;
      ST_STP_B: if (ph_end) st_n = ST_STP_C;
      ST_STP_C: if (ph_end) st_n = ST_CHK;
      ST_CHK:   st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_FIRST;
      ph          <= '0;
      pc          <= '0;
      sc          <= '0;
      scl_lo_o    <= (ST_FIRST == ST_LOW);
      sda_lo_o    <= 1'b0;
      slave_rst_o <= (ST_FIRST == ST_RST);
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      lockup_o    <= 1'b0;
    end else begin
      st <= st_n;
      if (st_n != st || st_n == ST_IDLE) ph <= '0;
      else if (!stall)                   ph <= ph + PH_W'(1);
      sc <= stall ? sc + SW'(1) : '0;
      if (st == ST_IDLE)                        pc <= '0;
      else if (st == ST_HIGH && scl_i && ph_end) pc <= pc + CW'(1);
      scl_lo_o    <= (st_n == ST_LOW) || (st_n == ST_STP_A);
      sda_lo_o    <= (st_n == ST_STP_A) || (st_n == ST_STP_B);
      slave_rst_o <= (st_n == ST_RST);
      if (st == ST_IDLE && start_i) begin
        done_o   <= 1'b0;
        fail_o   <= 1'b0;
        lockup_o <= lock_i;
      end
      if (st == ST_CHK) begin
        done_o <= sda_i;
        fail_o <= !sda_i;
      end
      if (st == ST_HIGH && st_n == ST_IDLE) fail_o <= 1'b1;
    end
  end

  // R9: a stretched clock freezes the high-phase count
  assert_stretch_pauses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && st_n == ST_HIGH) |=> (ph == $past(ph)));
  // R2: never more pulses than configured
  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= CW'(PULSES));
  // R2: SDA is left alone while clocking
  assert_sda_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW || st == ST_HIGH) |-> !sda_lo_o);
  // R4: every finished run leaves exactly one outcome flag
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o ^ fail_o));
  // R3: SDA is released only after SCL has been let go
  assert_stop_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_lo_o) |-> !scl_lo_o);
endmodule

// File: rtl/bus_unjam.sv
module bus_unjam #(
  parameter int DIV           = 250,
  parameter int PULSES        = 10,
  parameter int STRETCH_LIM   = 2000,
  parameter bit EARLY_EXIT    = 1'b0,
  parameter bit USE_SLAVE_RST = 1'b0,
  parameter int RST_CYC       = 8,
  parameter int TW            = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recov_req_i,
  input  logic          gain_wait_i,
  input  logic [TW-1:0] gain_limit_i,
  input  logic          xfer_wait_i,
  input  logic [TW-1:0] xfer_limit_i,
  input  logic          m_scl_lo_i,
  input  logic          m_sda_lo_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_lo_o,
  output logic          sda_lo_o,
  output logic          slave_rst_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          lockup_o
);
  localparam int NTO = 2;

  logic [NTO-1:0] wait_v, trip_v;
  logic [TW-1:0]  limit_v [NTO];
  logic start, seq_scl, seq_sda;

  assign wait_v     = {xfer_wait_i, gain_wait_i};
  assign limit_v[0] = gain_limit_i;
  assign limit_v[1] = xfer_limit_i;

  for (genvar g = 0; g < NTO; g++) begin : g_to
    unjam_timeout #(.TW(TW)) u_to (
      .clk(clk), .rst_n(rst_n), .hold_i(busy_o),
      .wait_i(wait_v[g]), .limit_i(limit_v[g]), .trip_o(trip_v[g])
    );
  end

  assign start = !busy_o && (recov_req_i || (|trip_v));

  unjam_seq #(
    .DIV(DIV), .PULSES(PULSES), .STRETCH_LIM(STRETCH_LIM),
    .EARLY_EXIT(EARLY_EXIT), .USE_SLAVE_RST(USE_SLAVE_RST), .RST_CYC(RST_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lock_i(|trip_v),
    .scl_i(scl_i), .sda_i(sda_i), .busy_o(busy_o),
    .scl_lo_o(seq_scl), .sda_lo_o(seq_sda), .slave_rst_o(slave_rst_o),
    .done_o(done_o), .fail_o(fail_o), .lockup_o(lockup_o)
  );

  assign scl_lo_o = busy_o ? seq_scl : m_scl_lo_i;
  assign sda_lo_o = busy_o ? seq_sda : m_sda_lo_i;

  // R7: a new run starts only from idle, with clean outcome flags
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!done_o && !fail_o));
endmodule

// File: tb/bus_unjam_test.sv
module bus_unjam_test;
  localparam int CLK_P = 10;
  localparam int D = 4, P = 10, SL = 20, RC = 6, TW = 8;
  localparam int FULL = 2*D*P + 3*D + 1;

  logic clk = 0, rst_n = 0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // main instance and its bus model
  logic req = 0, gw = 0, xw = 0, mscl = 0, msda = 0, stretch = 0, hold_en = 1;
  logic [TW-1:0] gl = 0, xl = 0;
  logic scl_lo, sda_lo, srst, busy, done, fail, lock;
  int rise_cnt = 0, rel_at = 9;
  logic sda_at_rise = 1;
  wire scl_line = !scl_lo && !stretch;
  wire hold = hold_en && (rise_cnt < rel_at);
  wire sda_line = !sda_lo && !hold;
  always @(posedge scl_line) begin rise_cnt++; sda_at_rise = sda_line; end

  bus_unjam #(.DIV(D), .PULSES(P), .STRETCH_LIM(SL), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .recov_req_i(req), .gain_wait_i(gw), .gain_limit_i(gl),
    .xfer_wait_i(xw), .xfer_limit_i(xl), .m_scl_lo_i(mscl), .m_sda_lo_i(msda),
    .scl_i(scl_line), .sda_i(sda_line), .scl_lo_o(scl_lo), .sda_lo_o(sda_lo),
    .slave_rst_o(srst), .busy_o(busy), .done_o(done), .fail_o(fail), .lockup_o(lock));

  // slave-reset variant
  logic r_scl, r_sda, r_srst, r_busy, r_done, r_fail, r_lock;
  bus_unjam #(.DIV(D), .PULSES(P), .STRETCH_LIM(SL), .USE_SLAVE_RST(1'b1), .RST_CYC(RC), .TW(TW)) uut_rst (
    .clk(clk), .rst_n(rst_n), .recov_req_i(1'b0), .gain_wait_i(1'b0), .gain_limit_i('0),
    .xfer_wait_i(1'b0), .xfer_limit_i('0), .m_scl_lo_i(1'b0), .m_sda_lo_i(1'b0),
    .scl_i(!r_scl), .sda_i(!r_sda), .scl_lo_o(r_scl), .sda_lo_o(r_sda),
    .slave_rst_o(r_srst), .busy_o(r_busy), .done_o(r_done), .fail_o(r_fail), .lockup_o(r_lock));

  // early-exit variant
  logic e_scl, e_sda, e_srst, e_busy, e_done, e_fail, e_lock;
  bus_unjam #(.DIV(D), .PULSES(P), .STRETCH_LIM(SL), .EARLY_EXIT(1'b1), .TW(TW)) uut_early (
    .clk(clk), .rst_n(rst_n), .recov_req_i(1'b0), .gain_wait_i(1'b0), .gain_limit_i('0),
    .xfer_wait_i(1'b0), .xfer_limit_i('0), .m_scl_lo_i(1'b0), .m_sda_lo_i(1'b0),
    .scl_i(!e_scl), .sda_i(!e_sda), .scl_lo_o(e_scl), .sda_lo_o(e_sda),
    .slave_rst_o(e_srst), .busy_o(e_busy), .done_o(e_done), .fail_o(e_fail), .lockup_o(e_lock));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // start a run by request; returns busy length in cycles
  task automatic run_rec(input int stretch_len, input bit poke, output int cyc);
    int n = 0;
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    if (stretch_len != 0) stretch = 1;
    while (busy && n < 5000) begin
      n++;
      if (stretch_len > 0 && n == D + stretch_len + 1) stretch = 0;
      if (poke && n == 2) begin
        check("R8 master SDA masked while busy", sda_lo, 0);
        check("R8 sequencer owns SCL while busy", scl_lo, 1);
      end
      if (poke && n == 3) req = 1;
      if (poke && n == 4) req = 0;
      @(negedge clk);
    end
    stretch = 0;
    cyc = n;
  endtask

  task automatic t_reset();
    int ca = 0, cr = 0, ce = 0, cs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 busy at reset release", busy, 1);
    check("R1 SCL pulled at reset release", scl_lo, 1);
    check("R1 SDA free at reset release", sda_lo, 0);
    check("R11 slave reset strobe at release", r_srst, 1);
    for (int i = 0; i < 2000 && (busy || r_busy || e_busy); i++) begin
      if (busy) ca++;
      if (r_busy) cr++;
      if (e_busy) ce++;
      if (r_srst) cs++;
      @(negedge clk);
    end
    check("R2 power-up run length", ca, FULL);
    check("R2 SCL rises (pulses plus STOP)", rise_cnt, P + 1);
    check("R3 SDA low at STOP clock rise", sda_at_rise, 0);
    check("R3 bus free after STOP", scl_line && sda_line, 1);
    check("R4 done after released SDA", done, 1);
    check("R4 no fail", fail, 0);
    check("R5 no lockup flag on power-up run", lock, 0);
    check("R11 reset variant run length", cr, RC + 3*D + 1);
    check("R11 strobe width", cs, RC);
    check("R11 reset variant done", r_done, 1);
    check("R12 early exit run length", ce, 5*D + 1);
    check("R12 early exit done", e_done, 1);
  endtask

  task automatic t_passthru();
    @(negedge clk); mscl = 1; msda = 0;
    @(negedge clk);
    check("R8 idle SCL follows master", scl_lo, 1);
    check("R8 idle SDA follows master", sda_lo, 0);
    mscl = 0; msda = 1;
    @(negedge clk);
    check("R8 idle SCL follows master b", scl_lo, 0);
    check("R8 idle SDA follows master b", sda_lo, 1);
    mscl = 0; msda = 0;
  endtask

  task automatic t_request();
    int c, r0;
    hold_en = 1; rel_at = rise_cnt + 3; r0 = rise_cnt;
    mscl = 0; msda = 1;
    run_rec(0, 1'b1, c);
    mscl = 0; msda = 0;
    check("R7 request run length, re-request ignored", c, FULL);
    check("R13 full pulse count despite early release", rise_cnt - r0, P + 1);
    check("R7 lockup clear on request", lock, 0);
    check("R4 done", done, 1);
  endtask

  task automatic t_stuck();
    int c;
    hold_en = 1; rel_at = 32'h7fffffff;
    run_rec(0, 1'b0, c);
    check("R4 stuck run length", c, FULL);
    check("R4 fail on stuck SDA", fail, 1);
    check("R4 done clear on stuck SDA", done, 0);
    hold_en = 0;
  endtask

  task automatic t_timer(input bit xfer, input int lim);
    int hits = 0, c = 0;
    string tg = xfer ? "R6" : "R5";
    @(negedge clk);
    if (xfer) xl = TW'(lim); else gl = TW'(lim);
    if (xfer) xw = 1; else gw = 1;
    repeat (lim - 1) @(negedge clk);
    xw = 0; gw = 0;
    check({tg, " short wait no recovery"}, busy, 0);
    @(negedge clk);
    check({tg, " short wait no recovery later"}, busy, 0);
    if (xfer) xw = 1; else gw = 1;
    repeat (lim - 1) @(negedge clk);
    check({tg, " one edge before limit"}, busy, 0);
    @(negedge clk);
    xw = 0; gw = 0;
    check({tg, " recovery at limit"}, busy, 1);
    while (busy && c < 5000) begin c++; @(negedge clk); end
    check({tg, " lockup flag"}, lock, 1);
    check({tg, " done after timeout run"}, done, 1);
    xl = 0; gl = 0;
    if (xfer) xw = 1; else gw = 1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy) hits++; end
    xw = 0; gw = 0;
    check({tg, " limit zero disables"}, hits, 0);
  endtask

  task automatic t_stretch();
    int c;
    run_rec(7, 1'b0, c);
    check("R9 stretch adds exact cycles", c, FULL + 7);
    check("R9 done after stretch", done, 1);
  endtask

  task automatic t_stall();
    int c;
    run_rec(-1, 1'b0, c);
    check("R10 stalled SCL run length", c, D + SL);
    check("R10 fail on stalled SCL", fail, 1);
    check("R10 SCL released", scl_lo, 0);
    check("R10 SDA released", sda_lo, 0);
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_request();
    t_stuck();
    t_timer(1'b0, 6);
    t_timer(1'b1, 3);
    t_stretch();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule